// File: doc/BRIEF.md
# UART Interrupt Source Generator

This block turns status signals from a UART's transmit and receive paths into five interrupt lines: transmit, receive, modem-status, receive-timeout and a combined line. Its inputs are the FIFO fill levels, the holding-register-empty and receive-buffer-full flags, the two flow-control lines, per-character push and pop strobes, and a bit-period tick. A mode input chooses between FIFO rules, which use fill-level thresholds, and single-register rules, which follow the holding and buffer flags directly.

Each source has its own enable bit. The gated sources appear on a four-bit identification output that a register read returns. Any write to that register clears a latched modem-status event. The combined line is set whenever at least one gated source is set. A driver can therefore enable only the combined line and read the identification value to find out which source needs service.

Top module: `uart_irq_gen`

## Requirements
- R1: With `fifoEn` high, the transmit source sets when `txLevel` is below half the FIFO depth (8 at the default depth of 16) and clears when it is above half. At exactly half it keeps its previous value. The result shows one clock edge after the level is sampled.
- R2: With `fifoEn` low, the transmit source equals `holdEmpty` one clock edge later, so a write to the holding register, which drops `holdEmpty`, clears it.
- R3: With `fifoEn` high, the receive source is set while `rxLevel` is at least half the depth and clear below that. With `fifoEn` low, it equals `rxFull`. In both modes the result shows one edge later.
- R4: A change on `ctsIn` or `dsrIn` sets the modem-status source three clock edges after the change is first sampled, because of two synchronizer stages and one change-detect stage. The source stays set until a cycle with `idWrite` high, and is clear one edge after that cycle.
- R5: In FIFO mode, with `rxLevel` nonzero, the receive-timeout source sets on the 32nd `bitTick` counted since the last `rxPush` or `rxPop`. Each push or pop restarts the count. The source clears when `rxLevel` is 0, and it never sets while `fifoEn` is low.
- R6: `irqEnable` bit 0 gates modem-status, bit 1 gates receive, bit 2 gates transmit and bit 3 gates receive-timeout. A disabled source drives neither its output nor the combined line, and it reads as 0 in `idOut`. A latched modem event is kept and shows again once its enable bit is set.
- R7: `anyIrq` is high exactly when at least one of the four gated outputs is high.
- R8: `idOut` bit 0 is modem-status, bit 1 is receive, bit 2 is transmit and bit 3 is receive-timeout. Each bit equals its gated output.
- R9: While `rstN` is low, every output is 0 and the timeout count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoEn | input | 1 | 1 selects FIFO threshold rules, 0 selects single-register rules |
| txLevel | input | 5 | Transmit FIFO fill count |
| rxLevel | input | 5 | Receive FIFO fill count |
| holdEmpty | input | 1 | Transmit holding register is empty |
| rxFull | input | 1 | Receive buffer holds a character |
| rxPush | input | 1 | One-cycle strobe: a character was received |
| rxPop | input | 1 | One-cycle strobe: the receive FIFO was read |
| ctsIn | input | 1 | Clear-to-send line, asynchronous |
| dsrIn | input | 1 | Data-set-ready line, asynchronous |
| bitTick | input | 1 | One-cycle pulse per bit period |
| irqEnable | input | 4 | Per-source enable bits, in `idOut` order |
| idWrite | input | 1 | Write strobe to the identification register |
| idOut | output | 4 | Gated sources, read as the identification register |
| txIrq | output | 1 | Transmit interrupt |
| rxIrq | output | 1 | Receive interrupt |
| modemIrq | output | 1 | Modem-status interrupt |
| timeoutIrq | output | 1 | Receive-timeout interrupt |
| anyIrq | output | 1 | Combined interrupt |

## Verification
The level-based transmit and receive sources are registered, so they are due one edge after their inputs. The modem-status source is due three edges after a line change, and the timeout source on the edge that samples the 32nd tick. The enable gating is combinational and follows `irqEnable` within the same cycle. The bench drives inputs just after a falling edge and samples on a later falling edge, after exactly the number of rising edges each result needs. At one edge short of the due point it checks that the old value still holds: two edges for the modem source and 31 ticks for the timeout.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  localparam int NUM_SRC  = 4;
  localparam int ID_MODEM = 0;
  localparam int ID_RX    = 1;
  localparam int ID_TX    = 2;
  localparam int ID_TMO   = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic setModem;      // a synchronized flow-control line changed
    logic clrModem;      // identification register written
    logic restartTimer;  // idle count back to zero
    logic flushTimeout;  // timeout source forced clear
    logic tick;          // one bit period elapsed
  } irqStrobes_t;

endpackage

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int LVL_W       = $clog2(DEPTH + 1),
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic             ctsIn,
  input  logic             dsrIn,
  input  logic             bitTick,
  input  logic             idWrite,
  output irqStrobes_t      strb
);

  localparam int LINES = 2;

  logic [SYNC_STAGES-1:0][LINES-1:0] syncReg;
  logic [LINES-1:0]                  prevLines;
  logic                              rxEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg[0] <= '0;
    else       syncReg[0] <= {dsrIn, ctsIn};
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg[s] <= '0;
        else       syncReg[s] <= syncReg[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLines <= '0;
    else       prevLines <= syncReg[SYNC_STAGES-1];
  end

  assign rxEmpty = (rxLevel == '0);

  always_comb begin
    strb.setModem     = (syncReg[SYNC_STAGES-1] != prevLines);
    strb.clrModem     = idWrite;
    strb.restartTimer = rxPush | rxPop | rxEmpty | ~fifoEn;
    strb.flushTimeout = rxEmpty | ~fifoEn;
    strb.tick         = bitTick;
  end

endmodule

// File: rtl/uirq_datapath.sv
module uirq_datapath
  import uirq_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int LVL_W        = $clog2(DEPTH + 1),
  parameter int TIMEOUT_BITS = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fifoEn,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic               holdEmpty,
  input  logic               rxFull,
  input  logic [NUM_SRC-1:0] irqEnable,
  input  irqStrobes_t        strb,
  output logic [NUM_SRC-1:0] srcGated
);

  localparam int               CNT_W    = $clog2(TIMEOUT_BITS);
  localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_BITS - 1);

  logic [NUM_SRC-1:0] srcState;
  logic [CNT_W-1:0]   idleCnt;

  // transmit: hysteresis around half in FIFO mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   srcState[ID_TX] <= 1'b0;
    else if (!fifoEn)            srcState[ID_TX] <= holdEmpty;
    else if (txLevel < HALF_LVL) srcState[ID_TX] <= 1'b1;
    else if (txLevel > HALF_LVL) srcState[ID_TX] <= 1'b0;
  end

  // receive: threshold or buffer flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcState[ID_RX] <= 1'b0;
    else       srcState[ID_RX] <= fifoEn ? (rxLevel >= HALF_LVL) : rxFull;
  end

  // modem status: a change sets, a register write clears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              srcState[ID_MODEM] <= 1'b0;
    else if (strb.setModem) srcState[ID_MODEM] <= 1'b1;
    else if (strb.clrModem) srcState[ID_MODEM] <= 1'b0;
  end

  // receive idle counter, saturating at its last value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               idleCnt <= '0;
    else if (strb.restartTimer)              idleCnt <= '0;
    else if (strb.tick && idleCnt != LAST_CNT) idleCnt <= idleCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                srcState[ID_TMO] <= 1'b0;
    else if (strb.flushTimeout)               srcState[ID_TMO] <= 1'b0;
    else if (!strb.restartTimer && strb.tick && idleCnt == LAST_CNT)
                                              srcState[ID_TMO] <= 1'b1;
  end

  assign srcGated = srcState & irqEnable;

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uirq_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int TIMEOUT_BITS = 32,
  parameter int SYNC_STAGES  = 2,
  parameter int LVL_W        = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic             holdEmpty,
  input  logic             rxFull,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic             ctsIn,
  input  logic             dsrIn,
  input  logic             bitTick,
  input  logic [3:0]       irqEnable,
  input  logic             idWrite,
  output logic [3:0]       idOut,
  output logic             txIrq,
  output logic             rxIrq,
  output logic             modemIrq,
  output logic             timeoutIrq,
  output logic             anyIrq
);

  irqStrobes_t        strb;
  logic [NUM_SRC-1:0] srcGated;

  uirq_ctrl #(
    .DEPTH(DEPTH), .LVL_W(LVL_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .rxLevel(rxLevel),
    .rxPush(rxPush), .rxPop(rxPop), .ctsIn(ctsIn), .dsrIn(dsrIn),
    .bitTick(bitTick), .idWrite(idWrite), .strb(strb)
  );

  uirq_datapath #(
    .DEPTH(DEPTH), .LVL_W(LVL_W), .TIMEOUT_BITS(TIMEOUT_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .txLevel(txLevel),
    .rxLevel(rxLevel), .holdEmpty(holdEmpty), .rxFull(rxFull),
    .irqEnable(irqEnable), .strb(strb), .srcGated(srcGated)
  );

  assign idOut      = srcGated;
  assign modemIrq   = srcGated[ID_MODEM];
  assign rxIrq      = srcGated[ID_RX];
  assign txIrq      = srcGated[ID_TX];
  assign timeoutIrq = srcGated[ID_TMO];
  assign anyIrq     = |srcGated;

endmodule

// File: rtl/uirq_checker.sv
module uirq_checker #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             fifoEn,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel,
  input logic             rxFull,
  input logic             ctsIn,
  input logic             dsrIn,
  input logic [3:0]       irqEnable,
  input logic             idWrite,
  input logic [3:0]       idOut,
  input logic             txIrq,
  input logic             rxIrq,
  input logic             modemIrq,
  input logic             timeoutIrq,
  input logic             anyIrq
);

  localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(DEPTH / 2);

  logic [2:0] warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          warm <= '0;
    else if (warm != 3'd7) warm <= warm + 3'd1;
  end

  // R1: low transmit level seen with FIFO on sets the transmit line
  assert_tx_low_level_R1: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 3'd2 && $past(fifoEn) && $past(txLevel) < HALF_LVL && irqEnable[2]) |-> txIrq);

  // R3: full buffer in single-register mode sets the receive line
  assert_rx_buffer_R3: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 3'd2 && !$past(fifoEn) && $past(rxFull) && irqEnable[1]) |-> rxIrq);

  // R4: a write with no pending line change clears modem status
  assert_modem_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 3'd4 && idWrite && $past(ctsIn, 2) == $past(ctsIn, 3)
     && $past(dsrIn, 2) == $past(dsrIn, 3)) |=> !modemIrq);

  // R5: an empty receive FIFO leaves no timeout
  assert_timeout_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 3'd2 && $past(rxLevel) == '0) |-> !timeoutIrq);

  // R6: a disabled source never reaches its line
  assert_gate_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(~irqEnable & {timeoutIrq, txIrq, rxIrq, modemIrq}));

  // R7: the combined line rises only with some identified source
  assert_combined_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyIrq) |-> (idOut != 4'd0));

  // R8: identification bits match the individual lines
  assert_id_map_R8: assert property (@(posedge clk) disable iff (!rstN)
    idOut == {timeoutIrq, txIrq, rxIrq, modemIrq});

endmodule

bind uart_irq_gen uirq_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .txLevel(txLevel),
  .rxLevel(rxLevel), .rxFull(rxFull), .ctsIn(ctsIn), .dsrIn(dsrIn),
  .irqEnable(irqEnable), .idWrite(idWrite), .idOut(idOut),
  .txIrq(txIrq), .rxIrq(rxIrq), .modemIrq(modemIrq),
  .timeoutIrq(timeoutIrq), .anyIrq(anyIrq)
);

// File: tb/test_uart_irq_gen.sv
module test_uart_irq_gen;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fifoEn = 1'b1;
  logic [4:0] txLevel = 5'd16;
  logic [4:0] rxLevel = 5'd0;
  logic       holdEmpty = 1'b0;
  logic       rxFull = 1'b0;
  logic       rxPush = 1'b0;
  logic       rxPop = 1'b0;
  logic       ctsIn = 1'b0;
  logic       dsrIn = 1'b0;
  logic       bitTick = 1'b0;
  logic [3:0] irqEnable = 4'hF;
  logic       idWrite = 1'b0;
  logic [3:0] idOut;
  logic       txIrq, rxIrq, modemIrq, timeoutIrq, anyIrq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_irq_gen i_uart_irq_gen (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .txLevel(txLevel),
    .rxLevel(rxLevel), .holdEmpty(holdEmpty), .rxFull(rxFull),
    .rxPush(rxPush), .rxPop(rxPop), .ctsIn(ctsIn), .dsrIn(dsrIn),
    .bitTick(bitTick), .irqEnable(irqEnable), .idWrite(idWrite),
    .idOut(idOut), .txIrq(txIrq), .rxIrq(rxIrq), .modemIrq(modemIrq),
    .timeoutIrq(timeoutIrq), .anyIrq(anyIrq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bitTick = 1'b1;
      @(negedge clk);
    end
    bitTick = 1'b0;
  endtask

  task automatic testReset();
    step(2);
    chk("R9 outputs in reset", {3'b0, anyIrq, idOut}, 8'h00);
    rstN = 1'b1;
    step(1);
    chk("R9 outputs after reset", {3'b0, anyIrq, idOut}, 8'h00);
  endtask

  task automatic testTxFifo();
    txLevel = 5'd3;  step(1); chk("R1 below half sets", txIrq, 1);
    txLevel = 5'd8;  step(1); chk("R1 at half holds set", txIrq, 1);
    txLevel = 5'd9;  step(1); chk("R1 above half clears", txIrq, 0);
    txLevel = 5'd8;  step(1); chk("R1 at half holds clear", txIrq, 0);
    txLevel = 5'd7;  step(1); chk("R1 below half again", txIrq, 1);
    txLevel = 5'd16; step(1); chk("R1 full clears", txIrq, 0);
  endtask

  task automatic testNoFifo();
    fifoEn = 1'b0;
    holdEmpty = 1'b1; step(1); chk("R2 holding empty", txIrq, 1);
    holdEmpty = 1'b0; step(1); chk("R2 holding written", txIrq, 0);
    rxFull = 1'b1;    step(1); chk("R3 buffer full", rxIrq, 1);
    rxFull = 1'b0;    step(1); chk("R3 buffer read", rxIrq, 0);
    fifoEn = 1'b1;    step(1);
  endtask

  task automatic testRxFifo();
    rxLevel = 5'd7;  step(1); chk("R3 below half", rxIrq, 0);
    rxLevel = 5'd8;  step(1); chk("R3 at half", rxIrq, 1);
    rxLevel = 5'd15; step(1); chk("R3 above half", rxIrq, 1);
    rxLevel = 5'd7;  step(1); chk("R3 read below half", rxIrq, 0);
    rxLevel = 5'd0;  step(1);
  endtask

  task automatic testModem();
    ctsIn = 1'b1;
    step(2); chk("R4 cts not yet", modemIrq, 0);
    step(1); chk("R4 cts after three edges", modemIrq, 1);
    chk("R8 modem id bit0", idOut, 4'b0001);
    step(3); chk("R4 stays latched", modemIrq, 1);
    idWrite = 1'b1; step(1); idWrite = 1'b0;
    chk("R4 write clears", modemIrq, 0);
    dsrIn = 1'b1;
    step(3); chk("R4 dsr change", modemIrq, 1);
    irqEnable = 4'b1110; step(1);
    chk("R6 modem gated", {3'b0, anyIrq, idOut}, 8'h00);
    irqEnable = 4'hF; step(1);
    chk("R6 modem kept while gated", modemIrq, 1);
    idWrite = 1'b1; step(1); idWrite = 1'b0;
    chk("R4 second clear", modemIrq, 0);
  endtask

  task automatic testTimeout();
    rxLevel = 5'd3;
    rxPush = 1'b1; step(1); rxPush = 1'b0;
    ticks(31); chk("R5 31 ticks idle", timeoutIrq, 0);
    ticks(1);  chk("R5 32nd tick sets", timeoutIrq, 1);
    chk("R8 timeout id bit3 with R7", {3'b0, anyIrq, idOut}, 8'h18);
    rxLevel = 5'd0; step(1); chk("R5 empty clears", timeoutIrq, 0);
    rxLevel = 5'd2;
    rxPush = 1'b1; step(1); rxPush = 1'b0;
    ticks(20);
    rxPop = 1'b1; step(1); rxPop = 1'b0;
    ticks(20); chk("R5 pop restarts count", timeoutIrq, 0);
    ticks(11); chk("R5 31 after restart", timeoutIrq, 0);
    ticks(1);  chk("R5 32 after restart", timeoutIrq, 1);
    fifoEn = 1'b0; step(1); chk("R5 cleared without FIFO", timeoutIrq, 0);
    ticks(40); chk("R5 no timeout without FIFO", timeoutIrq, 0);
    fifoEn = 1'b1; rxLevel = 5'd0; step(1);
  endtask

  task automatic testEnables();
    txLevel = 5'd0; step(1);
    chk("R7 tx drives combined", {3'b0, anyIrq, idOut}, 8'h14);
    irqEnable = 4'b1011; step(1);
    chk("R6 tx gated off", {3'b0, anyIrq, idOut}, 8'h00);
    chk("R6 tx line off", txIrq, 0);
    rxLevel = 5'd9; step(1);
    chk("R7 rx alone combined", {3'b0, anyIrq, idOut}, 8'h12);
    irqEnable = 4'hF; step(1);
    chk("R8 rx and tx bits", {3'b0, anyIrq, idOut}, 8'h16);
    rxLevel = 5'd0; txLevel = 5'd16; step(1);
    chk("R7 all clear", anyIrq, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    testReset();
    testTxFifo();
    testNoFifo();
    testRxFifo();
    testModem();
    testTimeout();
    testEnables();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule